// File: doc/BRIEF.md
# Buffered Serial Register Port with Profile Slots

This block is the write side of a synthesizer core's configuration port. A host frames each transaction by pulling the active-low select line low, clocks in one address byte and then as many data bytes as the addressed register needs, most significant byte first, and releases select. The serial lines and the update strobe are brought into the system clock domain by two-stage synchronizers. A complete write lands in a shadow (buffer) copy of the register. Nothing reaches the outputs until a rising edge on the update strobe, which copies every buffer into its live copy in the same clock.

The register set is a 32-bit control word, a 32-bit converter control word whose low 10 bits set the output level, a 32-bit tuning word, a 16-bit phase word, two 64-bit sweep words, a pair of 16-bit rate words and eight 48-bit profile slots. Each profile slot holds a phase word in its upper 16 bits and a tuning word in its lower 32. A transaction that names no register is ignored. A transaction cut short by select rising early is discarded.

The receiver is a five-state machine. ST_IDLE waits for select low (transition to ST_ADDR). ST_ADDR collects eight address bits. On the eighth bit it moves to ST_DATA for a known address, or to ST_SKIP for an unknown one. ST_DATA collects the register's byte count, then issues one write and moves to ST_DONE. ST_SKIP and ST_DONE ignore further clocks. Select going high sends every state back to ST_IDLE, and in ST_DATA this abandons the partial word.

Top module: `srp_regport`

## Requirements
- R1: After reset every live output is zero, except the converter control output, which reads 0x007F13FF (fixed upper pattern with level 0x3FF).
- R2: A complete write to address 3 (4 bytes, MSB first) changes the tuning output only after the next rising edge of the update strobe.
- R3: Byte counts per address are: 0, 2, 3 and 8 take 4 bytes; 4 takes 2 bytes; 6 and 7 take 8 bytes; 0x09 to 0x10 take 6 bytes. The first byte sent is the most significant byte of the word.
- R4: Address 0x09+i (i = 0..7) loads profile slot i, which appears at prof_o[i*48 +: 48], with the phase word in bits 47:32 and the tuning word in bits 31:0.
- R5: Only the low 10 bits of the converter control word are writable. Bits 31:10 of its output always read 22'h1FC4.
- R6: A transaction to an address outside the decoded set (for example 1, 5, 0x11, 0xFF) leaves every register unchanged.
- R7: If select rises before the addressed register's full byte count has arrived, nothing is stored.
- R8: Bytes sent after the full byte count within the same select period are ignored. The register keeps the first bytes.
- R9: The update copies on the rising edge only. Holding the strobe high does not pass on writes made while it stays high; the next rising edge does.
- R10: When a write completes in the same clock as an update edge, the live register takes the newly written value.
- R11: Between update edges every live output holds its value, whatever serial traffic occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Active-low transaction select |
| sck_i | input | 1 | Serial bit clock; data sampled on its rising edge |
| sdi_i | input | 1 | Serial data in |
| upd_i | input | 1 | Update strobe; rising edge copies buffers to live registers |
| ctrl_o | output | 32 | Live control word |
| dac_o | output | 32 | Live converter control word (fixed upper pattern, level in 9:0) |
| ftw_o | output | 32 | Live tuning word |
| pofs_o | output | 16 | Live phase word |
| lim_o | output | 64 | Live sweep limit pair |
| step_o | output | 64 | Live sweep step pair |
| rate_o | output | 32 | Live sweep rate pair |
| prof_o | output | 384 | Eight live 48-bit profile slots, slot i at bits i*48 +: 48 |

## Verification
The last bit of a write and an update edge can land on the same clock. In that clock the buffer is being written while it is also being copied to the live register. The bench provokes this by raising the update strobe exactly one system clock after the final serial clock edge. Both signals pass through synchronizers of equal depth, so the internal write pulse and the update edge meet. The live output is then judged against the newly written word, not the old buffer contents. The same timing is repeated on a profile slot so that the forwarding path is checked on a wide register as well as a narrow one.

// File: rtl/srp_pkg.sv
`timescale 1ns/1ps
package srp_pkg;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = 8 * MAX_BYTES;
    localparam int NPROF     = 8;
    localparam int PROF_W    = 48;
    localparam int LEVEL_W   = 10;
    localparam int NSLOT     = 7 + NPROF;
    localparam int SLOT_W    = $clog2(NSLOT);
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    localparam logic [7:0] PROF_BASE = 8'h09;
    localparam logic [31-LEVEL_W:0] DAC_RSV = 22'h1FC4;
    localparam logic [LEVEL_W-1:0]  LEVEL_RST = '1;

    // storage slot numbering
    localparam int SL_CTRL  = 0;
    localparam int SL_DAC   = 1;
    localparam int SL_FTW   = 2;
    localparam int SL_POW   = 3;
    localparam int SL_LIM   = 4;
    localparam int SL_STEP  = 5;
    localparam int SL_RATE  = 6;
    localparam int SL_PROF0 = 7;

    typedef struct packed {
        logic              ok;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  nbytes;
    } dec_t;

    function automatic int slot_bits(input int s);
        case (s)
            SL_CTRL, SL_FTW, SL_RATE: return 32;
            SL_DAC:                   return LEVEL_W;
            SL_POW:                   return 16;
            SL_LIM, SL_STEP:          return 64;
            default:                  return PROF_W;
        endcase
    endfunction

    function automatic int slot_off(input int s);
        int o;
        o = 0;
        for (int i = 0; i < s; i++) o += slot_bits(i);
        return o;
    endfunction

    localparam int TOT_W = slot_off(NSLOT);

    function automatic dec_t decode(input logic [7:0] a);
        dec_t d;
        d.ok     = 1'b1;
        d.slot   = '0;
        d.nbytes = '0;
        if (a == 8'h00) begin
            d.slot = SLOT_W'(SL_CTRL);  d.nbytes = CNT_W'(4);
        end else if (a == 8'h02) begin
            d.slot = SLOT_W'(SL_DAC);   d.nbytes = CNT_W'(4);
        end else if (a == 8'h03) begin
            d.slot = SLOT_W'(SL_FTW);   d.nbytes = CNT_W'(4);
        end else if (a == 8'h04) begin
            d.slot = SLOT_W'(SL_POW);   d.nbytes = CNT_W'(2);
        end else if (a == 8'h06) begin
            d.slot = SLOT_W'(SL_LIM);   d.nbytes = CNT_W'(8);
        end else if (a == 8'h07) begin
            d.slot = SLOT_W'(SL_STEP);  d.nbytes = CNT_W'(8);
        end else if (a == 8'h08) begin
            d.slot = SLOT_W'(SL_RATE);  d.nbytes = CNT_W'(4);
        end else if (a >= PROF_BASE && a < PROF_BASE + 8'(NPROF)) begin
            d.slot   = SLOT_W'(SL_PROF0) + SLOT_W'(a - PROF_BASE);
            d.nbytes = CNT_W'(PROF_W / 8);
        end else begin
            d.ok = 1'b0;
        end
        return d;
    endfunction
endpackage

// File: rtl/srp_sync.sv
`timescale 1ns/1ps
module srp_sync #(
    parameter int           W    = 1,
    parameter bit           EDGE = 1'b0,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST;
            s2_q <= RST;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    generate
        if (EDGE) begin : g_edge
            logic [W-1:0] s3_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s3_q <= RST;
                else        s3_q <= s2_q;
            end
            assign q_o = s2_q & ~s3_q;
        end else begin : g_lvl
            assign q_o = s2_q;
        end
    endgenerate
endmodule

// File: rtl/srp_shifter.sv
`timescale 1ns/1ps
module srp_shifter
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act_i,
    input  logic              sdi_i,
    input  logic              tick_i,
    output logic              wr_o,
    output logic [SLOT_W-1:0] wr_slot_o,
    output logic [DATA_W-1:0] wr_data_o
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_DATA, ST_SKIP, ST_DONE
    } st_t;

    st_t               state_q, state_d;
    logic [2:0]        bit_q;
    logic [CNT_W-1:0]  byte_q, need_q;
    logic [6:0]        ahist_q;
    logic [DATA_W-1:0] sh_q;
    logic [SLOT_W-1:0] slot_q;
    logic [7:0]        addr_full;
    dec_t              dec;
    logic              byte_end, frame_end;

    assign addr_full = {ahist_q, sdi_i};
    assign dec       = decode(addr_full);
    assign byte_end  = tick_i && (bit_q == 3'd7);
    assign frame_end = byte_end && (byte_q == need_q - CNT_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_act_i) state_d = ST_ADDR;
            ST_ADDR: begin
                if (!cs_act_i)     state_d = ST_IDLE;
                else if (byte_end) state_d = dec.ok ? ST_DATA : ST_SKIP;
            end
            ST_DATA: begin
                if (!cs_act_i)      state_d = ST_IDLE;
                else if (frame_end) state_d = ST_DONE;
            end
            ST_SKIP, ST_DONE: if (!cs_act_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and write pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            byte_q  <= '0;
            need_q  <= '0;
            ahist_q <= '0;
            sh_q    <= '0;
            slot_q  <= '0;
            wr_o    <= 1'b0;
        end else begin
            wr_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    bit_q   <= '0;
                    byte_q  <= '0;
                    ahist_q <= '0;
                    sh_q    <= '0;
                end
                ST_ADDR: begin
                    if (cs_act_i && tick_i) begin
                        bit_q   <= bit_q + 3'd1;
                        ahist_q <= addr_full[6:0];
                        if (byte_end) begin
                            slot_q <= dec.slot;
                            need_q <= dec.nbytes;
                        end
                    end
                end
                ST_DATA: begin
                    if (cs_act_i && tick_i) begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[DATA_W-2:0], sdi_i};
                        if (byte_end)  byte_q <= byte_q + CNT_W'(1);
                        if (frame_end) wr_o   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign wr_slot_o = slot_q;
    assign wr_data_o = sh_q;
endmodule

// File: rtl/srp_regbank.sv
`timescale 1ns/1ps
module srp_regbank
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              upd_i,
    output logic [TOT_W-1:0]  act_o
);
    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            localparam int BW  = slot_bits(s);
            localparam int OFF = slot_off(s);
            localparam logic [BW-1:0] RV = (s == SL_DAC) ? BW'(LEVEL_RST) : '0;

            logic          hit;
            logic [BW-1:0] buf_q, act_q, nxt;

            assign hit = wr_i && (wr_slot_i == SLOT_W'(s));
            // a write landing with the update edge is forwarded to the live copy
            assign nxt = hit ? wr_data_i[BW-1:0] : buf_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    buf_q <= RV;
                    act_q <= RV;
                end else begin
                    buf_q <= nxt;
                    if (upd_i) act_q <= nxt;
                end
            end

            assign act_o[OFF +: BW] = act_q;
        end
    endgenerate
endmodule

// File: rtl/srp_regport.sv
`timescale 1ns/1ps
module srp_regport
    import srp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csn_i,
    input  logic                    sck_i,
    input  logic                    sdi_i,
    input  logic                    upd_i,
    output logic [31:0]             ctrl_o,
    output logic [31:0]             dac_o,
    output logic [31:0]             ftw_o,
    output logic [15:0]             pofs_o,
    output logic [63:0]             lim_o,
    output logic [63:0]             step_o,
    output logic [31:0]             rate_o,
    output logic [NPROF*PROF_W-1:0] prof_o
);
    logic              csn_s, sdi_s, sck_rise, upd_rise, cs_act;
    logic              wr;
    logic [SLOT_W-1:0] wr_slot;
    logic [DATA_W-1:0] wr_data;
    logic [TOT_W-1:0]  act;

    srp_sync #(.W(2), .EDGE(1'b0), .RST(2'b01)) u_sync_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sdi_i, csn_i}),
        .q_o   ({sdi_s, csn_s})
    );

    srp_sync #(.W(2), .EDGE(1'b1), .RST(2'b00)) u_sync_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({upd_i, sck_i}),
        .q_o   ({upd_rise, sck_rise})
    );

    assign cs_act = ~csn_s;

    srp_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act_i  (cs_act),
        .sdi_i     (sdi_s),
        .tick_i    (sck_rise),
        .wr_o      (wr),
        .wr_slot_o (wr_slot),
        .wr_data_o (wr_data)
    );

    srp_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr),
        .wr_slot_i (wr_slot),
        .wr_data_i (wr_data),
        .upd_i     (upd_rise),
        .act_o     (act)
    );

    assign ctrl_o = act[slot_off(SL_CTRL) +: 32];
    assign dac_o  = {DAC_RSV, act[slot_off(SL_DAC) +: LEVEL_W]};
    assign ftw_o  = act[slot_off(SL_FTW) +: 32];
    assign pofs_o = act[slot_off(SL_POW) +: 16];
    assign lim_o  = act[slot_off(SL_LIM) +: 64];
    assign step_o = act[slot_off(SL_STEP) +: 64];
    assign rate_o = act[slot_off(SL_RATE) +: 32];
    assign prof_o = act[slot_off(SL_PROF0) +: NPROF*PROF_W];
endmodule

// File: rtl/srp_regport_chk.sv
`timescale 1ns/1ps
module srp_regport_chk
    import srp_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cs_act,
    input logic                    upd_rise,
    input logic                    wr,
    input logic [31:0]             ctrl,
    input logic [31:0]             dac,
    input logic [31:0]             ftw,
    input logic [15:0]             pofs,
    input logic [63:0]             lim,
    input logic [63:0]             step,
    input logic [31:0]             rate,
    input logic [NPROF*PROF_W-1:0] prof
);
    assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac == 32'h007F13FF && ctrl == 32'h0 && ftw == 32'h0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_rise |=> ($stable(ftw) && $stable(pofs) && $stable(lim)
                       && $stable(step) && $stable(rate) && $stable(dac)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_rise |=> ($stable(ctrl) && $stable(prof)));

    assert_one_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !wr);

    assert_write_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> $past(cs_act));
endmodule

bind srp_regport srp_regport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .upd_rise (upd_rise),
    .wr       (wr),
    .ctrl     (ctrl_o),
    .dac      (dac_o),
    .ftw      (ftw_o),
    .pofs     (pofs_o),
    .lim      (lim_o),
    .step     (step_o),
    .rate     (rate_o),
    .prof     (prof_o)
);

// File: tb/srp_regport_tb.sv
`timescale 1ns/1ps
module srp_regport_tb;
    logic clk = 1'b0, rst_n = 1'b0, csn = 1'b1, sck = 1'b0, sdi = 1'b0, upd = 1'b0;
    logic [31:0]  ctrl_o, dac_o, ftw_o, rate_o;
    logic [15:0]  pofs_o;
    logic [63:0]  lim_o, step_o;
    logic [383:0] prof_o;

    always #10 clk = ~clk;   // 50 MHz

    srp_regport u_dut (
        .clk(clk), .rst_n(rst_n), .csn_i(csn), .sck_i(sck), .sdi_i(sdi), .upd_i(upd),
        .ctrl_o(ctrl_o), .dac_o(dac_o), .ftw_o(ftw_o), .pofs_o(pofs_o),
        .lim_o(lim_o), .step_o(step_o), .rate_o(rate_o), .prof_o(prof_o)
    );

    int n_chk = 0, n_fail = 0;
    logic [63:0] bm [15];
    logic [63:0] am [15];

    function automatic int nbytes_of(input logic [7:0] a);
        if (a == 8'h00 || a == 8'h02 || a == 8'h03 || a == 8'h08) return 4;
        if (a == 8'h04) return 2;
        if (a == 8'h06 || a == 8'h07) return 8;
        if (a >= 8'h09 && a <= 8'h10) return 6;
        return 0;
    endfunction

    function automatic int slot_of(input logic [7:0] a);
        case (a)
            8'h00: return 0;
            8'h02: return 1;
            8'h03: return 2;
            8'h04: return 3;
            8'h06: return 4;
            8'h07: return 5;
            8'h08: return 6;
            default: return int'(a) - 2;
        endcase
    endfunction

    function automatic logic [63:0] wmask(input int s);
        int b;
        case (s)
            0, 2, 6: b = 32;
            1:       b = 10;
            3:       b = 16;
            4, 5:    b = 64;
            default: b = 48;
        endcase
        return (b == 64) ? '1 : ((64'd1 << b) - 64'd1);
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " ctrl"}, 64'(ctrl_o), am[0]);
        chk({tag, " dac"},  64'(dac_o),  64'({22'h1FC4, am[1][9:0]}));
        chk({tag, " ftw"},  64'(ftw_o),  am[2]);
        chk({tag, " pofs"}, 64'(pofs_o), am[3]);
        chk({tag, " lim"},  lim_o,       am[4]);
        chk({tag, " step"}, step_o,      am[5]);
        chk({tag, " rate"}, 64'(rate_o), am[6]);
        for (int i = 0; i < 8; i++)
            chk({tag, " prof"}, 64'(prof_o[i*48 +: 48]), am[7+i]);
    endtask

    task automatic model_write(input logic [7:0] a, input logic [127:0] d, input int nsend);
        int nb, s;
        logic [127:0] sh;
        nb = nbytes_of(a);
        if (nb == 0 || nsend < nb) return;
        s  = slot_of(a);
        sh = d >> ((nsend - nb) * 8);
        bm[s] = sh[63:0] & wmask(s);
    endtask

    task automatic send_bit(input logic b, input bit coll);
        sdi = b;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        if (coll) begin
            @(negedge clk);
            upd = 1'b1;
            @(negedge clk);
        end else begin
            repeat (2) @(negedge clk);
        end
        sck = 1'b0;
    endtask

    task automatic frame(input logic [7:0] a, input logic [127:0] d, input int nsend, input bit coll);
        csn = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 7; i >= 0; i--) send_bit(a[i], 1'b0);
        for (int k = 0; k < nsend; k++)
            for (int i = 7; i >= 0; i--)
                send_bit(d[(nsend-1-k)*8 + i], coll && (k == nsend-1) && (i == 0));
        repeat (3) @(negedge clk);
        csn = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [127:0] d, input int nsend);
        frame(a, d, nsend, 1'b0);
        model_write(a, d, nsend);
    endtask

    task automatic pulse_update();
        upd = 1'b1;
        repeat (4) @(negedge clk);
        upd = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 15; i++) am[i] = bm[i];
    endtask

    function automatic logic [7:0] pick_addr();
        int r;
        r = int'($urandom % 12);
        case (r)
            0: return 8'h00;  1: return 8'h02;  2: return 8'h03;  3: return 8'h04;
            4: return 8'h06;  5: return 8'h07;  6: return 8'h08;
            7, 8: return 8'h09 + 8'($urandom % 8);
            9: return 8'h01;  10: return 8'h05;
            default: return 8'h11 + 8'($urandom % 200);
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1337));
        for (int i = 0; i < 15; i++) bm[i] = 64'h0;
        bm[1] = 64'h3FF;
        for (int i = 0; i < 15; i++) am[i] = bm[i];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1 reset");
        chk("R1 dac reset word", 64'(dac_o), 64'h007F13FF);

        // R2: buffered until update
        wr(8'h03, 128'h12345678, 4);
        check_all("R2 before update");
        pulse_update();
        check_all("R2 after update");
        chk("R2 ftw", 64'(ftw_o), 64'h12345678);

        // R3: per-address byte counts
        wr(8'h04, 128'hABCD, 2);
        wr(8'h06, 128'h0123456789ABCDEF, 8);
        wr(8'h07, 128'hFEDCBA9876543210, 8);
        wr(8'h08, 128'h00FA01F4, 4);
        wr(8'h00, 128'h00A0B0C0, 4);
        pulse_update();
        check_all("R3");
        chk("R3 lim", lim_o, 64'h0123456789ABCDEF);

        // R4: profile slots
        wr(8'h09, 128'h1111_22223333, 6);
        wr(8'h10, 128'hAAAA_BBBBCCCC, 6);
        pulse_update();
        check_all("R4");
        chk("R4 slot0 phase", 64'(prof_o[47:32]), 64'h1111);
        chk("R4 slot7 tuning", 64'(prof_o[7*48 +: 32]), 64'hBBBBCCCC);

        // R5: converter control reserved bits
        wr(8'h02, 128'hFFFFFFFF, 4);
        pulse_update();
        chk("R5 all ones", 64'(dac_o), 64'h007F13FF);
        wr(8'h02, 128'h12345015, 4);
        pulse_update();
        chk("R5 level 0x015", 64'(dac_o), 64'h007F1015);
        check_all("R5");

        // R6: unknown addresses
        wr(8'h05, 128'hDEADBEEF, 4);
        wr(8'h01, 128'hCAFEF00D, 4);
        wr(8'h11, 128'h0102030405060708, 8);
        wr(8'hFF, 128'h55AA55AA, 4);
        pulse_update();
        check_all("R6");

        // R7: partial writes
        wr(8'h03, 128'h999999, 3);
        wr(8'h0A, 128'h7777_66665555, 5);
        wr(8'h06, 128'h1, 1);
        pulse_update();
        check_all("R7");

        // R8: extra bytes ignored
        wr(8'h04, 128'h13572468, 4);
        pulse_update();
        chk("R8 pofs", 64'(pofs_o), 64'h1357);
        check_all("R8");

        // R9: level-held update does not copy later writes
        upd = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 15; i++) am[i] = bm[i];
        wr(8'h03, 128'h0BADF00D, 4);
        check_all("R9 held high");
        upd = 1'b0;
        repeat (4) @(negedge clk);
        check_all("R9 after fall");
        pulse_update();
        check_all("R9 next rise");
        chk("R9 ftw", 64'(ftw_o), 64'h0BADF00D);

        // R10: write completing in the same clock as the update edge
        frame(8'h03, 128'h600DCAFE, 4, 1'b1);
        upd = 1'b0;
        repeat (4) @(negedge clk);
        model_write(8'h03, 128'h600DCAFE, 4);
        for (int i = 0; i < 15; i++) am[i] = bm[i];
        chk("R10 ftw forwarded", 64'(ftw_o), 64'h600DCAFE);
        frame(8'h0C, 128'h4242_31415926, 6, 1'b1);
        upd = 1'b0;
        repeat (4) @(negedge clk);
        model_write(8'h0C, 128'h4242_31415926, 6);
        for (int i = 0; i < 15; i++) am[i] = bm[i];
        check_all("R10 profile");

        // R11 and mixed: constrained random traffic
        for (int it = 0; it < 60; it++) begin
            logic [7:0]   a;
            logic [127:0] d;
            int nb, ns, mode;
            a    = pick_addr();
            d    = {$urandom, $urandom, $urandom, $urandom};
            nb   = nbytes_of(a);
            mode = int'($urandom % 4);
            if (nb == 0)        ns = 1 + int'($urandom % 8);
            else if (mode == 2) ns = nb - 1;
            else if (mode == 3) ns = nb + 1 + int'($urandom % 2);
            else                ns = nb;
            wr(a, d, ns);
            check_all("R11 hold between updates");
            if ($urandom % 2 == 0) begin
                pulse_update();
                check_all("R3 random after update");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule